// File: doc/BRIEF.md
# Frame-Sampled Line-Interface Lead Port

This block gives a host a six-lead general-purpose port for driving and reading the control leads of a subscriber line interface circuit. The host reaches it through a byte-wide register interface. Each write is a single-cycle strobe with an address and data. Reads are combinational: the addressed register appears on `reg_rdata` in the same cycle.

Each lead has a direction bit and an output data bit. Leads set as outputs drive the latched value. Leads set as inputs keep their pad driver disabled.

The lead levels seen at the pads pass through a two-stage synchronizer. A status register captures them on an 8 kHz frame strobe. The host therefore sees a snapshot that is refreshed once per frame, not the live pins. A separate 8-bit scratch register holds whatever is written to it. It exists only so that the host path can be tested.

Top module: `slic_lead_port`

## Requirements
- R1: Writing address 158 loads bits 5:0 into the direction register. A 1 in bit n drives `lead_oe[n]` high, which makes lead n an output. Reading address 158 returns the register.
- R2: After reset, the direction register is 0x0C, so only leads 2 and 3 are outputs. The data latch, the status register and the scratch register are all 0.
- R3: Writing address 159 loads bits 5:0 into the data latch. Reading address 159 returns the latch. For every output lead n, `lead_out[n]` equals latch bit n.
- R4: A lead configured as an input holds `lead_oe[n]` and `lead_out[n]` at 0, whatever the data latch holds.
- R5: Bits 7:6 of writes to addresses 158 and 159 are discarded. Bits 7:6 read as 0 at addresses 158, 159 and 160.
- R6: Address 160 returns the status register. On each cycle with `frame_tick` high, the status register captures the lead inputs through a two-flop synchronizer. A level present on `lead_in` for two clock edges before a strobe edge is visible the cycle after that edge. A level that arrived only one edge before the strobe is not captured. Without a strobe, the status register holds its value.
- R7: Writes to address 160 are ignored; the status value read back is unchanged by them.
- R8: Address 162 is an 8-bit read/write scratch register whose contents have no effect on `lead_oe` or `lead_out`.
- R9: Any other address reads as 0, and writes to it change no register and no lead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| frame_tick | input | 1 | One-cycle frame strobe, once per 125 us frame |
| lead_in | input | 6 | Levels seen at the lead pads |
| lead_out | output | 6 | Output value for each lead pad |
| lead_oe | output | 6 | Output enable for each lead pad, 1 = drive |

## Verification
The direction and data registers are driven with these patterns:
- all-ones and all-zeros;
- the reset pattern;
- values with bits 7:6 set, to separate kept bits from discarded ones.

With the latch full of ones under mixed directions, the tests tell gating by direction apart from gating by data.

The status path is tested in three ways:
- with alternating lead patterns and no strobe, to show that nothing reaches it between frames;
- with a strobe that comes only one edge after an input change, to show the synchronizer depth by still capturing the old level;
- with a second strobe that then captures the new level.

Writes to the status register, to the scratch register and to an unmapped address are each followed by readback of every register and of the lead pins.

// File: rtl/slic_lead_port.sv
module slic_lead_port #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int LEADS      = 6,
  parameter int ADDR_DIR   = 158,
  parameter int ADDR_DATA  = 159,
  parameter int ADDR_STAT  = 160,
  parameter int ADDR_TEST  = 162,
  parameter logic [LEADS-1:0] DIR_RST = 6'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             frame_tick,
  input  logic [LEADS-1:0] lead_in,
  output logic [LEADS-1:0] lead_out,
  output logic [LEADS-1:0] lead_oe
);

  localparam int PAD = DW - LEADS;

  logic [LEADS-1:0] dir_q, data_q, stat_q, sync1_q, sync2_q;
  logic [DW-1:0]    test_q;

  wire hit_dir  = reg_addr == AW'(ADDR_DIR);
  wire hit_data = reg_addr == AW'(ADDR_DATA);
  wire hit_stat = reg_addr == AW'(ADDR_STAT);
  wire hit_test = reg_addr == AW'(ADDR_TEST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= DIR_RST;
      data_q <= '0;
      test_q <= '0;
    end else if (reg_we) begin
      if (hit_dir)  dir_q  <= reg_wdata[LEADS-1:0];
      if (hit_data) data_q <= reg_wdata[LEADS-1:0];
      if (hit_test) test_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      stat_q  <= '0;
    end else begin
      sync1_q <= lead_in;
      sync2_q <= sync1_q;
      if (frame_tick) stat_q <= sync2_q;
    end
  end

  assign lead_oe  = dir_q;
  assign lead_out = data_q & dir_q;

  always_comb begin
    reg_rdata = '0;
    if (hit_dir)  reg_rdata = {{PAD{1'b0}}, dir_q};
    if (hit_data) reg_rdata = {{PAD{1'b0}}, data_q};
    if (hit_stat) reg_rdata = {{PAD{1'b0}}, stat_q};
    if (hit_test) reg_rdata = test_q;
  end

  assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && hit_dir) |=> lead_oe == $past(reg_wdata[LEADS-1:0]));

  assert_input_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_out & ~lead_oe) == '0);

  assert_data_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && hit_data) |=> (lead_out & lead_oe) == ($past(reg_wdata[LEADS-1:0]) & lead_oe));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_dir || hit_data || hit_stat) |-> reg_rdata[DW-1:LEADS] == '0);

  assert_hold_between_frames_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(stat_q));

  assert_frame_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> stat_q == $past(sync2_q));

  assert_stat_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && hit_stat && !frame_tick) |=> $stable(stat_q));

  assert_test_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && hit_test) |=> $stable(lead_oe) && $stable(lead_out));

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_dir || hit_data || hit_stat || hit_test) |-> reg_rdata == '0);

endmodule

// File: tb/test_slic_lead_port.sv
module test_slic_lead_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       frame_tick = 1'b0;
  logic [5:0] lead_in = '0;
  logic [5:0] lead_out, lead_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slic_lead_port i_slic_lead_port (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
    .lead_in(lead_in), .lead_out(lead_out), .lead_oe(lead_oe));

  // {req, addr, wdata, expected readback}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {8'd1, 8'd158, 8'h3F, 8'h3F},  // R1 all outputs
    {8'd5, 8'd158, 8'hC5, 8'h05},  // R5 upper bits dropped
    {8'd3, 8'd159, 8'hFF, 8'h3F},  // R3 and R5
    {8'd3, 8'd159, 8'h12, 8'h12},  // R3
    {8'd8, 8'd162, 8'hA5, 8'hA5},  // R8
    {8'd8, 8'd162, 8'h5A, 8'h5A},  // R8
    {8'd7, 8'd160, 8'hFF, 8'h00},  // R7 status unchanged
    {8'd9, 8'd161, 8'hFF, 8'h00},  // R9 unmapped
    {8'd1, 8'd158, 8'h00, 8'h00}   // R1 all inputs
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 oe", {2'b0, lead_oe}, 8'h0C);
    check("R2 out", {2'b0, lead_out}, 8'h00);
    rd(8'd158, v); check("R2 dir", v, 8'h0C);
    rd(8'd159, v); check("R2 data", v, 8'h00);
    rd(8'd160, v); check("R2 stat", v, 8'h00);
    rd(8'd162, v); check("R2 test", v, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], v);
      check($sformatf("R%0d vec%0d", VEC[i][31:24], i), v, VEC[i][7:0]);
    end

    // R3 R4: latch full of ones, mixed direction
    wr(8'd159, 8'h3F);
    wr(8'd158, 8'h0C);
    check("R4 out gated", {2'b0, lead_out}, 8'h0C);
    check("R1 oe", {2'b0, lead_oe}, 8'h0C);
    wr(8'd158, 8'h31);
    check("R4 out gated 2", {2'b0, lead_out}, 8'h31);
    wr(8'd159, 8'h10);
    check("R3 out", {2'b0, lead_out}, 8'h10);

    // R8: scratch write leaves leads alone
    wr(8'd162, 8'hFF);
    check("R8 oe", {2'b0, lead_oe}, 8'h31);
    check("R8 out", {2'b0, lead_out}, 8'h10);
    rd(8'd162, v); check("R8 read", v, 8'hFF);

    // R9: unmapped write changes nothing
    wr(8'd200, 8'h00);
    rd(8'd158, v); check("R9 dir", v, 8'h31);
    rd(8'd159, v); check("R9 data", v, 8'h10);
    rd(8'd162, v); check("R9 test", v, 8'hFF);
    check("R9 out", {2'b0, lead_out}, 8'h10);

    // R6: capture only on strobe
    @(negedge clk); lead_in = 6'h2A;
    repeat (4) @(negedge clk);
    rd(8'd160, v); check("R6 no strobe", v, 8'h00);
    tick();
    rd(8'd160, v); check("R6 capture", v, 8'h2A);
    lead_in = 6'h15;
    repeat (6) @(negedge clk);
    rd(8'd160, v); check("R6 hold", v, 8'h2A);
    tick();
    rd(8'd160, v); check("R6 capture 2", v, 8'h15);

    // R6 synchronizer depth: strobe one edge after change sees old level
    @(negedge clk); lead_in = 6'h3F;
    frame_tick = 1'b0;
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    rd(8'd160, v); check("R6 sync depth", v, 8'h15);
    tick();
    rd(8'd160, v); check("R6 late capture", v, 8'h3F);

    // R7: status write ignored
    wr(8'd160, 8'h00);
    rd(8'd160, v); check("R7 stat", v, 8'h3F);
    check("R7 oe", {2'b0, lead_oe}, 8'h31);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule